// File: doc/BRIEF.md
# Masked vector compress and expand unit

This unit rearranges the elements of a vector register under control of a per-element mask. In compress mode it gathers the source elements whose mask bit is set and packs them, lowest index first, into the low end of the destination. In expand mode it does the reverse. The next unused source element, starting from element 0, is dropped into each destination slot whose mask bit is set.

The unit scans the mask one element per cycle, up to the active vector length. On each cycle it drives a source read index and takes the element back on the same cycle. When a write is due, it drives a destination write with its index and data. Destination slots that get no write keep their old contents, because the register file only changes when the write enable is high. When the scan ends, the unit raises a one-cycle done pulse and presents the packed length, which is the population count of the mask over the active length.

Top module: `vmask_pack`

## Requirements
- R1: After reset, busy_o, done_o and wr_en_o are 0 and pop_o is 0.
- R2: With op_i = 0 (compress), scan cycle c (c = 0 .. vl-1, mask bit c belongs to element c) reads source index c. When mask bit c is set, that cycle writes the source element to destination index k, where k is the number of set mask bits below c.
- R3: With op_i = 1 (expand), scan cycle c reads source index k, where k is the number of set mask bits below c. When mask bit c is set, that cycle writes that element to destination index c.
- R4: In expand, no write is issued to a destination slot whose mask bit is clear, so that slot keeps its previous contents.
- R5: In compress, destination slots at or above the popcount receive no write and keep their contents.
- R6: Mask bits at indices at or above the vector length have no effect, and those elements receive no write.
- R7: A start on an idle cycle puts the first scan cycle in the next cycle, with busy_o high for exactly vl cycles. done_o pulses for one cycle right after the last scan cycle, with pop_o equal to the popcount of the mask over the active length.
- R8: A start with vector length 0 issues no write and pulses done_o in the next cycle, with pop_o = 0.
- R9: A start_i asserted while busy_o is high is ignored.
- R10: A vector length above MAXVL is treated as MAXVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation when idle |
| op_i | input | 1 | 0 = compress, 1 = expand |
| mask_i | input | MAXVL | Per-element mask, bit i for element i |
| vlen_i | input | LW | Active vector length |
| busy_o | output | 1 | Scan in progress |
| src_idx_o | output | IW | Source element read index |
| src_data_i | input | DW | Source element returned for src_idx_o |
| wr_en_o | output | 1 | Destination write enable |
| wr_idx_o | output | IW | Destination write index |
| wr_data_o | output | DW | Destination write data |
| done_o | output | 1 | One-cycle completion pulse |
| pop_o | output | LW | Packed length (mask popcount over active length) |

## Verification
The hardest case to reach is a start request that arrives in the middle of a scan. If it were accepted, it would change the opcode and mask partway through and corrupt the index streams. The bench raises start_i, with the other opcode and a different mask, during the second scan cycle of a running operation. It then checks that the write stream and the final destination still match the first request. The length boundaries are reached directly: zero, a partial length that hides set mask bits, and a length above the maximum.

// File: rtl/vmask_pack.sv
module vmask_pack #(
  parameter int MAXVL = 8,
  parameter int DW    = 16,
  localparam int IW   = (MAXVL > 1) ? $clog2(MAXVL) : 1,
  localparam int LW   = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             op_i,
  input  logic [MAXVL-1:0] mask_i,
  input  logic [LW-1:0]    vlen_i,
  output logic             busy_o,
  output logic [IW-1:0]    src_idx_o,
  input  logic [DW-1:0]    src_data_i,
  output logic             wr_en_o,
  output logic [IW-1:0]    wr_idx_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             done_o,
  output logic [LW-1:0]    pop_o
);

  logic             busy_q, done_q, op_q;
  logic [MAXVL-1:0] mask_q, act_mask;
  logic [IW-1:0]    i_q;
  logic [LW-1:0]    k_q, vl_q, pop_q, vl_eff, act_pop;

  assign vl_eff = (int'(vlen_i) > MAXVL) ? LW'(MAXVL) : vlen_i;

  always_comb begin
    act_pop = '0;
    for (int j = 0; j < MAXVL; j++) begin
      act_mask[j] = mask_i[j] && (j < int'(vl_eff));
      act_pop     = act_pop + LW'(act_mask[j]);
    end
  end

  wire hit  = busy_q && mask_q[i_q];
  wire last = (LW'(i_q) == vl_q - LW'(1));

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign pop_o     = pop_q;
  assign src_idx_o = op_q ? IW'(k_q) : i_q;
  assign wr_idx_o  = op_q ? i_q : IW'(k_q);
  assign wr_en_o   = hit;
  assign wr_data_o = src_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= 1'b0;
      mask_q <= '0;
      i_q    <= '0;
      k_q    <= '0;
      vl_q   <= '0;
      pop_q  <= '0;
    end else if (busy_q) begin
      i_q    <= i_q + IW'(1);
      k_q    <= k_q + LW'(hit);
      busy_q <= !last;
      done_q <= last;
    end else if (start_i) begin
      op_q   <= op_i;
      mask_q <= act_mask;
      vl_q   <= vl_eff;
      pop_q  <= act_pop;
      i_q    <= '0;
      k_q    <= '0;
      busy_q <= (vl_eff != '0);
      done_q <= (vl_eff == '0);
    end else begin
      done_q <= 1'b0;
    end
  end

  // R7
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (k_q == pop_o) && !busy_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2
  pack_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (k_q <= LW'(i_q)));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(op_q) && $stable(mask_q) && $stable(vl_q)));

  // R7
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last) |=> busy_o && (i_q == $past(i_q) + IW'(1)));

endmodule

// File: tb/vmask_pack_tb.sv
module vmask_pack_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXVL = 8;
  localparam int DW = 16;
  localparam int IW = 3;
  localparam int LW = 4;

  logic clk = 0, rst_n = 0, start_i = 0, op_i = 0;
  logic [MAXVL-1:0] mask_i = '0;
  logic [LW-1:0] vlen_i = '0;
  logic busy_o, wr_en_o, done_o;
  logic [IW-1:0] src_idx_o, wr_idx_o;
  logic [DW-1:0] src_data_i, wr_data_o;
  logic [LW-1:0] pop_o;

  logic [DW-1:0] src_mem [MAXVL];
  logic [DW-1:0] dst_mem [MAXVL];
  logic [DW-1:0] exp_dst [MAXVL];
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign src_data_i = src_mem[src_idx_o];

  always @(posedge clk) if (wr_en_o) dst_mem[wr_idx_o] <= wr_data_o;

  vmask_pack #(.MAXVL(MAXVL), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .mask_i(mask_i),
    .vlen_i(vlen_i), .busy_o(busy_o), .src_idx_o(src_idx_o), .src_data_i(src_data_i),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
    .done_o(done_o), .pop_o(pop_o));

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic run(input bit op, input logic [MAXVL-1:0] m, input int vl,
                     input bit poke, input int seed, input string r);
    int veff, k;
    int q_en[$], q_idx[$], q_dat[$];
    veff = (vl > MAXVL) ? MAXVL : vl;
    for (int j = 0; j < MAXVL; j++) begin
      src_mem[j] = DW'(16'h1000 + j * 17 + seed * 257);
      dst_mem[j] = DW'(16'hD000 + j + seed);
      exp_dst[j] = dst_mem[j];
    end
    k = 0;
    for (int c = 0; c < veff; c++) begin
      if (m[c]) begin
        int ei, ed;
        ei = op ? c : k;
        ed = op ? int'(src_mem[k]) : int'(src_mem[c]);
        exp_dst[ei] = DW'(ed);
        q_en.push_back(1); q_idx.push_back(ei); q_dat.push_back(ed);
        k++;
      end else begin
        q_en.push_back(0); q_idx.push_back(0); q_dat.push_back(0);
      end
    end
    @(negedge clk);
    start_i = 1; op_i = op; mask_i = m; vlen_i = LW'(vl);
    @(negedge clk);
    start_i = 0;
    for (int c = 0; c < veff; c++) begin
      if (poke && c == 1) begin
        start_i = 1; op_i = !op; mask_i = ~m; vlen_i = LW'(2);
      end
      if (poke && c == 2) start_i = 0;
      chk(busy_o === 1'b1, {r, " R7 busy"}, busy_o, 1);
      chk(wr_en_o === q_en[c][0], {r, " wr_en"}, wr_en_o, q_en[c]);
      if (q_en[c] == 1) begin
        chk(wr_idx_o == IW'(q_idx[c]), {r, " wr_idx"}, wr_idx_o, q_idx[c]);
        chk(wr_data_o == DW'(q_dat[c]), {r, " wr_data"}, wr_data_o, q_dat[c]);
      end
      @(negedge clk);
    end
    start_i = 0;
    chk(done_o === 1'b1 && busy_o === 1'b0, {r, " R7 done"}, done_o, 1);
    chk(pop_o == LW'(k), {r, " R7 pop"}, pop_o, k);
    @(negedge clk);
    chk(done_o === 1'b0, {r, " R7 single pulse"}, done_o, 0);
    for (int j = 0; j < MAXVL; j++)
      chk(dst_mem[j] == exp_dst[j], {r, " dst contents"}, dst_mem[j], exp_dst[j]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o === 0 && done_o === 0 && wr_en_o === 0, "R1 reset outputs", busy_o, 0);
    chk(pop_o === '0, "R1 reset pop", pop_o, 0);
    rst_n = 1;
    // R2 R5 compress, elements 1,4,5,7 pack to 0..3
    run(0, 8'b1011_0010, 8, 0, 1, "R2 R5 compress");
    // R3 R4 expand
    run(1, 8'b1011_0010, 8, 0, 2, "R3 R4 expand");
    // R6 partial length hides upper set bits
    run(0, 8'hFF, 5, 0, 3, "R6 compress vl5");
    run(1, 8'hAA, 3, 0, 4, "R6 expand vl3");
    // R8 zero length
    run(0, 8'hFF, 0, 0, 5, "R8 zero length");
    // R10 oversized length
    run(0, 8'h81, 12, 0, 6, "R10 clamp");
    // R9 start while busy
    run(0, 8'b0110_1001, 8, 1, 7, "R9 start ignored");
    run(1, 8'hFF, 8, 0, 8, "R3 expand all");
    run(0, 8'h00, 8, 0, 9, "R5 empty mask");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule